// File: doc/BRIEF.md
# Codec Register Access Controller

This block lets a CPU reach the registers of an external audio codec one access at a time. Software writes a 32-bit control word holding a read/write flag, a 7-bit register index and 16 bits of write data, and sets a "go" bit in the same word. The engine offers the word to the serial link as a command slot. When the link accepts it, the go bit drops, and software polls that bit to learn that the command has left.

For a read, the engine remembers the requested index and watches the incoming status slots. A returned slot updates the status register only if its echoed index equals the requested one. The status register then shows the echoed index, the 16-bit data and a fresh-data flag, and reading the status register clears that flag. The same handshake also carries a warm link reset request. The block presents codec ready indications and static power-down and link-off requests as plain fields.

Top module: `codec_reg_access`

## Requirements
- R1: After reset the control word reads 0, the fresh-data flag (status bit 17) is 0, slot_out_valid is 0, warm_rst is 0 and cmd_overrun is 0.
- R2: A control write whose go bit (bit 16) is 1, made while the go bit is clear, stores the word. From the next cycle slot_out_valid is 1 and slot_out_cmd equals the written word.
- R3: While slot_out_valid is 1 and slot_out_ready is 0, the command holds steady. After the edge where both are 1, the go bit and slot_out_valid read 0, and each such edge is exactly one command.
- R4: A control write made while the go bit is 1 leaves the control word unchanged and sets cmd_overrun. cmd_overrun then stays 1 until reset.
- R5: After a read command (bit 31 = 1, index in bits 30:24) is issued, an incoming slot whose 8-bit index equals the index zero-extended is captured. Status then shows that index in bits 31:24, the data in bits 15:0 and bit 17 = 1.
- R6: An incoming slot whose index differs from the pending one, or that arrives with no read pending, leaves status bits 31:24, 17 and 15:0 unchanged.
- R7: A status read strobe clears status bit 17 from the next cycle, unless a matching slot is captured in the same cycle.
- R8: Issuing a write command (bit 31 = 0) cancels any pending read, so later incoming slots are ignored.
- R9: Issuing a command with bit 17 set produces a single one-cycle pulse on warm_rst, in the cycle after the issuing edge.
- R10: Status bit 23 follows codec_pri_rdy and status bit 22 follows codec_sec_rdy.
- R11: Control bits 21, 20 and 18 drive pd_pri, pd_sec and link_off. ctl_rdata returns the stored control word.
- R12: A control write with bit 16 = 0 stores the word but issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control word to write |
| ctl_rdata | output | 32 | Stored control word |
| sts_re | input | 1 | Status register read strobe |
| sts_rdata | output | 32 | Status word |
| cmd_overrun | output | 1 | Sticky flag: control write made while busy |
| slot_out_valid | output | 1 | Command slot offered to the link |
| slot_out_ready | input | 1 | Link takes the command slot this cycle |
| slot_out_cmd | output | 32 | Command slot contents |
| slot_in_valid | input | 1 | Incoming status slot present |
| slot_in_index | input | 8 | Echoed register index |
| slot_in_data | input | 16 | Returned register data |
| codec_pri_rdy | input | 1 | Primary codec ready |
| codec_sec_rdy | input | 1 | Secondary codec ready |
| warm_rst | output | 1 | One-cycle warm link reset request |
| pd_pri | output | 1 | Primary codec power-down request |
| pd_sec | output | 1 | Secondary codec power-down request |
| link_off | output | 1 | Link shutdown request |

## Verification
The assertions assume that the link treats slot_out_ready as a per-cycle acceptance and needs no stable ready. They also assume that the status read strobe and an incoming slot may coincide, with capture winning. The bench drives every input at the falling edge and changes slot_out_ready only while it is held low to create backpressure. Its codec model answers one cycle-spaced slot a fixed number of cycles after each accepted read. It also counts accepted commands, so a handshake that issues twice or not at all is seen at the ports.

// File: rtl/cra_pkg.sv
`timescale 1ns/1ps
package cra_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 7;
    localparam int ECHO_W = 8;
    localparam int DATA_W = 16;

    // control word fields
    localparam int C_RD      = 31;
    localparam int C_IDX_LSB = 24;
    localparam int C_PD_PRI  = 21;
    localparam int C_PD_SEC  = 20;
    localparam int C_LINKOFF = 18;
    localparam int C_WARM    = 17;
    localparam int C_GO      = 16;

    // status word fields
    localparam int S_IDX_LSB = 24;
    localparam int S_PRI     = 23;
    localparam int S_SEC     = 22;
    localparam int S_FRESH   = 17;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } pend_t;

    typedef struct packed {
        logic [ECHO_W-1:0] idx;
        logic [DATA_W-1:0] data;
        logic              fresh;
    } reply_t;

    function automatic logic [IDX_W-1:0] ctl_index(input logic [WORD_W-1:0] w);
        return w[C_IDX_LSB +: IDX_W];
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input reply_t r,
                                                      input logic pri,
                                                      input logic sec);
        logic [WORD_W-1:0] s;
        s = '0;
        s[S_IDX_LSB +: ECHO_W] = r.idx;
        s[S_PRI]               = pri;
        s[S_SEC]               = sec;
        s[S_FRESH]             = r.fresh;
        s[DATA_W-1:0]          = r.data;
        return s;
    endfunction
endpackage

// File: rtl/cra_ctl_reg.sv
`timescale 1ns/1ps
module cra_ctl_reg
    import cra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              link_ready,
    output logic [WORD_W-1:0] ctl_q,
    output logic              issue,
    output logic              overrun,
    output logic              warm_pulse
);
    assign issue = ctl_q[C_GO] && link_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            overrun    <= 1'b0;
            warm_pulse <= 1'b0;
        end else begin
            warm_pulse <= issue && ctl_q[C_WARM];
            if (issue)
                ctl_q[C_GO] <= 1'b0;
            if (we && !ctl_q[C_GO])
                ctl_q <= wdata;
            if (we && ctl_q[C_GO])
                overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/cra_reply_match.sv
`timescale 1ns/1ps
module cra_reply_match
    import cra_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [WORD_W-1:0] cmd,
    input  logic              in_valid,
    input  logic [ECHO_W-1:0] in_idx,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd_strobe,
    output reply_t            reply
);
    pend_t pend;
    logic  hit;

    assign hit = in_valid && pend.busy &&
                 (in_idx == {{(ECHO_W-IDX_W){1'b0}}, pend.idx});

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            reply <= '0;
        end else begin
            if (hit)
                pend.busy <= 1'b0;
            if (issue) begin
                pend.busy <= cmd[C_RD];
                pend.idx  <= ctl_index(cmd);
            end
            if (hit) begin
                reply.idx   <= in_idx;
                reply.data  <= in_data;
                reply.fresh <= 1'b1;
            end else if (rd_strobe) begin
                reply.fresh <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/codec_reg_access.sv
`timescale 1ns/1ps
module codec_reg_access
    import cra_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic        sts_re,
    output logic [31:0] sts_rdata,
    output logic        cmd_overrun,
    output logic        slot_out_valid,
    input  logic        slot_out_ready,
    output logic [31:0] slot_out_cmd,
    input  logic        slot_in_valid,
    input  logic [7:0]  slot_in_index,
    input  logic [15:0] slot_in_data,
    input  logic        codec_pri_rdy,
    input  logic        codec_sec_rdy,
    output logic        warm_rst,
    output logic        pd_pri,
    output logic        pd_sec,
    output logic        link_off
);
    logic [WORD_W-1:0] ctl_q;
    logic              issue;
    reply_t            reply;

    cra_ctl_reg u_ctl (
        .clk        (clk),
        .rst        (rst),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .link_ready (slot_out_ready),
        .ctl_q      (ctl_q),
        .issue      (issue),
        .overrun    (cmd_overrun),
        .warm_pulse (warm_rst)
    );

    cra_reply_match u_match (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .cmd       (ctl_q),
        .in_valid  (slot_in_valid),
        .in_idx    (slot_in_index),
        .in_data   (slot_in_data),
        .rd_strobe (sts_re),
        .reply     (reply)
    );

    assign ctl_rdata      = ctl_q;
    assign slot_out_cmd   = ctl_q;
    assign slot_out_valid = ctl_q[C_GO];
    assign pd_pri         = ctl_q[C_PD_PRI];
    assign pd_sec         = ctl_q[C_PD_SEC];
    assign link_off       = ctl_q[C_LINKOFF];
    assign sts_rdata      = pack_status(reply, codec_pri_rdy, codec_sec_rdy);
endmodule

// File: rtl/cra_checker.sv
`timescale 1ns/1ps
module cra_checker (
    input logic        clk,
    input logic        rst,
    input logic        ctl_we,
    input logic [31:0] ctl_rdata,
    input logic        sts_re,
    input logic [31:0] sts_rdata,
    input logic        cmd_overrun,
    input logic        slot_out_valid,
    input logic        slot_out_ready,
    input logic [31:0] slot_out_cmd,
    input logic        slot_in_valid,
    input logic        warm_rst
);
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        slot_out_valid && !slot_out_ready |=> slot_out_valid && $stable(slot_out_cmd)); // R3
    AST_GO_DROPS: assert property (@(posedge clk) disable iff (rst)
        slot_out_valid && slot_out_ready |=> !slot_out_valid); // R3
    AST_BUSY_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        ctl_we && slot_out_valid && !slot_out_ready |=> $stable(ctl_rdata) && cmd_overrun); // R4
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        cmd_overrun |=> cmd_overrun); // R4
    AST_FRESH_CLEARED: assert property (@(posedge clk) disable iff (rst)
        sts_re && !slot_in_valid |=> !sts_rdata[17]); // R7
    AST_REPLY_QUIET: assert property (@(posedge clk) disable iff (rst)
        !slot_in_valid |=> $stable(sts_rdata[31:24]) && $stable(sts_rdata[15:0])); // R6
    AST_WARM_SINGLE: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> !warm_rst); // R9
endmodule

bind codec_reg_access cra_checker u_cra_chk (
    .clk            (clk),
    .rst            (rst),
    .ctl_we         (ctl_we),
    .ctl_rdata      (ctl_rdata),
    .sts_re         (sts_re),
    .sts_rdata      (sts_rdata),
    .cmd_overrun    (cmd_overrun),
    .slot_out_valid (slot_out_valid),
    .slot_out_ready (slot_out_ready),
    .slot_out_cmd   (slot_out_cmd),
    .slot_in_valid  (slot_in_valid),
    .warm_rst       (warm_rst)
);

// File: tb/codec_reg_access_test.sv
`timescale 1ns/1ps
module codec_reg_access_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        sts_re = 1'b0;
    logic [31:0] sts_rdata;
    logic        cmd_overrun;
    logic        slot_out_valid;
    logic        slot_out_ready = 1'b1;
    logic [31:0] slot_out_cmd;
    logic        slot_in_valid = 1'b0;
    logic [7:0]  slot_in_index = '0;
    logic [15:0] slot_in_data = '0;
    logic        codec_pri_rdy = 1'b1;
    logic        codec_sec_rdy = 1'b0;
    logic        warm_rst, pd_pri, pd_sec, link_off;

    int checks = 0;
    int failures = 0;
    int cmd_count = 0;
    localparam int LAT = 4;

    // {index[6:0], data[15:0]}
    localparam logic [22:0] VEC [0:5] = '{
        {7'h00, 16'h1234}, {7'h7f, 16'hffff}, {7'h26, 16'h0000},
        {7'h2c, 16'hbb80}, {7'h40, 16'h8001}, {7'h15, 16'h5a5a}};

    codec_reg_access uut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk)
        if (!rst && slot_out_valid && slot_out_ready) cmd_count <= cmd_count + 1;

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [31:0] w);
        ctl_we = 1'b1; ctl_wdata = w;
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic send_slot(input logic [7:0] idx, input logic [15:0] d);
        slot_in_valid = 1'b1; slot_in_index = idx; slot_in_data = d;
        tick();
        slot_in_valid = 1'b0;
    endtask

    task automatic rd_sts();
        sts_re = 1'b1;
        tick();
        sts_re = 1'b0;
    endtask

    function automatic logic [31:0] rd_cmd(input logic [6:0] idx);
        return {1'b1, idx, 8'h00, 16'h0001 << 0} | 32'h0001_0000;
    endfunction

    initial begin
        int c0;
        logic [31:0] w;
        logic [31:0] keep;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 32'h0);
        chk("R1 fresh", {31'h0, sts_rdata[17]}, 32'h0);
        chk("R1 valid", {31'h0, slot_out_valid}, 32'h0);
        chk("R1 overrun", {31'h0, cmd_overrun}, 32'h0);
        chk("R1 warm", {31'h0, warm_rst}, 32'h0);
        // R10 ready mirrors
        chk("R10 pri", {31'h0, sts_rdata[23]}, 32'h1);
        chk("R10 sec", {31'h0, sts_rdata[22]}, 32'h0);
        codec_pri_rdy = 1'b0; codec_sec_rdy = 1'b1;
        #0.1;
        chk("R10 swap", {30'h0, sts_rdata[23:22]}, 32'h1);

        // vector table: R2, R3, R5, R7
        for (int i = 0; i < 6; i++) begin
            w = {1'b1, VEC[i][22:16], 8'h00, 16'h0000} | 32'h0001_0000;
            c0 = cmd_count;
            wr_ctl(w);
            chk("R2 valid", {31'h0, slot_out_valid}, 32'h1);
            chk("R2 cmd", slot_out_cmd, w);
            tick();
            chk("R3 go cleared", {31'h0, ctl_rdata[16]}, 32'h0);
            chk("R3 one command", cmd_count - c0, 32'd1);
            repeat (LAT) tick();
            send_slot({1'b0, VEC[i][22:16]}, VEC[i][15:0]);
            chk("R5 index", {24'h0, sts_rdata[31:24]}, {25'h0, VEC[i][22:16]});
            chk("R5 data", {16'h0, sts_rdata[15:0]}, {16'h0, VEC[i][15:0]});
            chk("R5 fresh", {31'h0, sts_rdata[17]}, 32'h1);
            rd_sts();
            chk("R7 fresh cleared", {31'h0, sts_rdata[17]}, 32'h0);
        end

        // R6 mismatched index, then stray slot with nothing pending
        wr_ctl(32'h8501_0000);  // read index 5
        tick();
        keep = sts_rdata;
        send_slot(8'h06, 16'hdead);
        chk("R6 mismatch ignored", sts_rdata & 32'hff02_ffff, keep & 32'hff02_ffff);
        send_slot(8'h85, 16'hdead);
        chk("R6 high bit mismatch", sts_rdata & 32'hff02_ffff, keep & 32'hff02_ffff);
        send_slot(8'h05, 16'hc0de);
        chk("R5 late match", sts_rdata & 32'hff02_ffff, 32'h0502_c0de);
        keep = sts_rdata;
        send_slot(8'h05, 16'h1111);
        chk("R6 none pending", sts_rdata & 32'hff02_ffff, keep & 32'hff02_ffff);

        // R7 strobe coincident with capture: capture wins
        wr_ctl(32'h8901_0000);  // read index 9
        tick();
        sts_re = 1'b1;
        send_slot(8'h09, 16'h7777);
        sts_re = 1'b0;
        chk("R7 capture wins", {31'h0, sts_rdata[17]}, 32'h1);
        rd_sts();

        // R8 write command cancels pending read
        wr_ctl(32'h8a01_0000);  // read index 10
        tick();
        wr_ctl(32'h0a01_4242);  // write index 10
        tick();
        keep = sts_rdata;
        send_slot(8'h0a, 16'h9999);
        chk("R8 read cancelled", sts_rdata & 32'hff02_ffff, keep & 32'hff02_ffff);

        // R12 no go bit: stored, not issued
        c0 = cmd_count;
        wr_ctl(32'h0300_00aa);
        chk("R12 stored", ctl_rdata, 32'h0300_00aa);
        tick();
        chk("R12 not issued", {31'h0, slot_out_valid}, 32'h0);
        chk("R12 no command", cmd_count - c0, 32'd0);

        // R11 static requests
        wr_ctl(32'h0034_0000);
        chk("R11 pd_pri", {31'h0, pd_pri}, 32'h1);
        chk("R11 pd_sec", {31'h0, pd_sec}, 32'h1);
        chk("R11 link_off", {31'h0, link_off}, 32'h1);
        wr_ctl(32'h0000_0000);
        chk("R11 cleared", {29'h0, pd_pri, pd_sec, link_off}, 32'h0);

        // R9 warm reset pulse
        wr_ctl(32'h0003_0000);
        chk("R9 before issue", {31'h0, warm_rst}, 32'h0);
        tick();
        chk("R9 pulse", {31'h0, warm_rst}, 32'h1);
        tick();
        chk("R9 single cycle", {31'h0, warm_rst}, 32'h0);

        // R4 write while busy, R3 hold under backpressure
        slot_out_ready = 1'b0;
        c0 = cmd_count;
        wr_ctl(32'h8c01_0000);
        wr_ctl(32'h0d01_5555);
        chk("R4 word kept", ctl_rdata, 32'h8c01_0000);
        chk("R4 overrun", {31'h0, cmd_overrun}, 32'h1);
        tick();
        chk("R3 held", slot_out_cmd, 32'h8c01_0000);
        slot_out_ready = 1'b1;
        tick();
        chk("R3 issued once", cmd_count - c0, 32'd1);
        chk("R3 go cleared", {31'h0, slot_out_valid}, 32'h0);
        repeat (3) tick();
        chk("R4 sticky", {31'h0, cmd_overrun}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule